// File: doc/BRIEF.md
# Data-Memory Wait-State Zone Controller

This block connects a processor core's data-memory port to a 24-bit external bus. A 14-bit data address falls in one of three kinds of space: one of five external zones, the on-chip RAM window starting at 0x3800, or the control region that runs from the end of that RAM to 0x3FFF. Each external zone has its own 3-bit wait count. An external access drives a chip select and one read or write strobe, and holds them for the zone's wait count. For the other two kinds of space the block only raises a flag and answers the core in the same cycle. Peripherals mapped into the external zones are accessed the same way as memory.

The sequencer has three states. IDLE waits for a request. WAIT holds the strobes while the remaining count is above one. LAST is the final strobe cycle and asserts ready. The transitions are:
- IDLE to LAST: an external request to a zone whose count is zero.
- IDLE to WAIT: an external request to a zone whose count is nonzero.
- WAIT to WAIT: the remaining count is above one; it decrements.
- WAIT to LAST: the remaining count reaches one.
- LAST to IDLE: always.

The wait counts are written through a small configuration port (zone index, value, write enable). Every count comes out of reset at seven. The core holds its request until it sees ready and drops it in the following cycle.

Top module: `wsz_ctrl`

## Requirements
- R1: Addresses 0x0000–0x03FF select zone 0, 0x0400–0x07FF zone 1, 0x0800–0x2FFF zone 2, 0x3000–0x33FF zone 3 and 0x3400–0x37FF zone 4. The access uses that zone's wait count.
- R2: An address from 0x3800 up to 0x3800+INT_WORDS-1 raises `core_int_hit` and `core_ready` in the request cycle and drives no external strobe. With the default INT_WORDS of 512, the last such address is 0x39FF.
- R3: An address from 0x3800+INT_WORDS through 0x3FFF raises `core_ctrl_hit` and `core_ready` in the request cycle and drives no external strobe.
- R4: After reset every zone's wait count is 7. While idle, all three active-low strobes are high, `ext_oe` is low and `core_ready` is low with no request.
- R5: During an external access, `ext_sel_n` is low for the whole access. `ext_rd_n` is low for a read and `ext_wr_n` is low for a write. The two are never low together.
- R6: A zone with wait count N holds the strobes for N+1 consecutive cycles. `core_ready` is high in the last of those cycles and in no other.
- R7: A configuration write with `cfg_zone` 0–4 sets that zone's 3-bit count. A write with `cfg_zone` 5–7 changes no count.
- R8: A configuration write during an external access does not change that access's length. It does take effect for the next access.
- R9: During a write access `ext_dout[23:8]` carries the write data and `ext_dout[7:0]` is zero. `ext_oe` is high only during write accesses.
- R10: For a read access, `core_rdata` equals `ext_din[23:8]` in the cycle `core_ready` is high.
- R11: `ext_addr` carries the request address, unchanged, for every strobe cycle of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req | input | 1 | Core requests an access, held until ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 14 | Data-memory word address |
| core_wdata | input | 16 | Write data |
| core_ready | output | 1 | Access completes this cycle |
| core_rdata | output | 16 | Read data, valid with ready |
| core_int_hit | output | 1 | Request targets on-chip RAM |
| core_ctrl_hit | output | 1 | Request targets the control region |
| cfg_we | input | 1 | Wait-count write enable |
| cfg_zone | input | 3 | Zone index to write |
| cfg_ws | input | 3 | New wait count |
| ext_addr | output | 14 | External address |
| ext_dout | output | 24 | External bus output data |
| ext_oe | output | 1 | External bus output enable |
| ext_din | input | 24 | External bus input data |
| ext_sel_n | output | 1 | Data-memory chip select, active low |
| ext_rd_n | output | 1 | Read strobe / output enable, active low |
| ext_wr_n | output | 1 | Write strobe, active low |

## Verification
Every zone is tried with every wait count from 0 to 7, for both reads and writes. This separates an off-by-one in the count from an error in strobe polarity or in the data lanes. An address sweep in steps of 0x80, plus every boundary address, runs with each zone given a different count. A mis-decoded address then shows up as the wrong access length or the wrong flag. Writes to zone indices 5–7, and a count change made in the middle of an access, show whether a stray write or a late write reaches the counter.

// File: rtl/wsz_pkg.sv
package wsz_pkg;
    localparam int ADDR_W    = 14;
    localparam int DATA_W    = 16;
    localparam int BUS_W     = 24;
    localparam int WS_W      = 3;
    localparam int NUM_ZONES = 5;
    localparam int ZIDX_W    = 3;
    localparam int LANE_LO   = BUS_W - DATA_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_LAST = 2'd2
    } wsz_state_e;

    // Lower bound of zone z; zone NUM_ZONES gives the start of on-chip RAM.
    function automatic logic [ADDR_W-1:0] zone_base(input int z);
        case (z)
            0:       zone_base = 14'h0000;
            1:       zone_base = 14'h0400;
            2:       zone_base = 14'h0800;
            3:       zone_base = 14'h3000;
            4:       zone_base = 14'h3400;
            default: zone_base = 14'h3800;
        endcase
    endfunction
endpackage

// File: rtl/wsz_decode.sv
module wsz_decode
    import wsz_pkg::*;
#(
    parameter int INT_WORDS = 512
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ext_hit,
    output logic [ZIDX_W-1:0] zone_idx,
    output logic              int_hit,
    output logic              ctrl_hit
);
    localparam int INT_START = int'(zone_base(NUM_ZONES));
    localparam int INT_END   = INT_START + INT_WORDS;

    logic [NUM_ZONES-1:0] zhit;

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        assign zhit[z] = (addr >= zone_base(z)) && (addr < zone_base(z + 1));
    end

    always_comb begin
        zone_idx = '0;
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (zhit[z]) zone_idx = ZIDX_W'(z);
        end
    end

    assign ext_hit  = |zhit;
    assign int_hit  = (int'(addr) >= INT_START) && (int'(addr) < INT_END);
    assign ctrl_hit = (int'(addr) >= INT_END);
endmodule

// File: rtl/wsz_wsregs.sv
module wsz_wsregs
    import wsz_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ZIDX_W-1:0]              wr_zone,
    input  logic [WS_W-1:0]                wr_val,
    output logic [NUM_ZONES-1:0][WS_W-1:0] ws_q
);
    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ws_q[z] <= '1;
            end else if (wr_en && (wr_zone == ZIDX_W'(z))) begin
                ws_q[z] <= wr_val;
            end
        end

        p_reset_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (ws_q[z] == '1));
    end

    p_ignore_bad_zone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_zone) >= NUM_ZONES)) |=> $stable(ws_q));
endmodule

// File: rtl/wsz_seq.sv
module wsz_seq
    import wsz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_wdata,
    input  logic [WS_W-1:0]   go_ws,
    input  logic [BUS_W-1:0]  ext_din,
    output logic              idle,
    output logic              last,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [BUS_W-1:0]  ext_dout,
    output logic              ext_oe,
    output logic              ext_sel_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);
    wsz_state_e        state_q, state_d;
    logic [WS_W-1:0]   cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              we_q;
    logic              active;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = (go_ws == '0) ? ST_LAST : ST_WAIT;
            ST_WAIT: if (cnt_q == WS_W'(1)) state_d = ST_LAST;
            ST_LAST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Access context and remaining count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && go) begin
                cnt_q   <= go_ws;
                addr_q  <= go_addr;
                wdata_q <= go_wdata;
                we_q    <= go_we;
            end else if (state_q == ST_WAIT) begin
                cnt_q <= cnt_q - WS_W'(1);
            end
            if (state_q == ST_LAST && !we_q) begin
                rdata_q <= ext_din[BUS_W-1:LANE_LO];
            end
        end
    end

    // Outputs
    always_comb begin
        active    = (state_q != ST_IDLE);
        idle      = (state_q == ST_IDLE);
        last      = (state_q == ST_LAST);
        ext_sel_n = !active;
        ext_rd_n  = !(active && !we_q);
        ext_wr_n  = !(active && we_q);
        ext_oe    = active && we_q;
        ext_addr  = active ? addr_q : '0;
        ext_dout  = (active && we_q) ? {wdata_q, {LANE_LO{1'b0}}} : '0;
        rdata     = last ? ext_din[BUS_W-1:LANE_LO] : rdata_q;
    end

    p_rdwr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));
    p_strobe_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> !ext_sel_n);
    p_wait_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |=> (state_q == ST_WAIT || state_q == ST_LAST));
    p_last_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAST) |=> (state_q == ST_IDLE));
    p_oe_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_oe |-> (!ext_wr_n && ext_rd_n));
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel_n && $past(!ext_sel_n)) |-> $stable(ext_addr));
endmodule

// File: rtl/wsz_ctrl.sv
module wsz_ctrl
    import wsz_pkg::*;
#(
    parameter int INT_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ready,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_int_hit,
    output logic              core_ctrl_hit,
    input  logic              cfg_we,
    input  logic [ZIDX_W-1:0] cfg_zone,
    input  logic [WS_W-1:0]   cfg_ws,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [BUS_W-1:0]  ext_dout,
    output logic              ext_oe,
    input  logic [BUS_W-1:0]  ext_din,
    output logic              ext_sel_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);
    logic                           dec_ext, dec_int, dec_ctrl;
    logic [ZIDX_W-1:0]              dec_zone;
    logic [NUM_ZONES-1:0][WS_W-1:0] ws_q;
    logic [WS_W-1:0]                sel_ws;
    logic                           seq_idle, seq_last, go;

    wsz_decode #(.INT_WORDS(INT_WORDS)) u_dec (
        .addr     (core_addr),
        .ext_hit  (dec_ext),
        .zone_idx (dec_zone),
        .int_hit  (dec_int),
        .ctrl_hit (dec_ctrl)
    );

    wsz_wsregs u_ws (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_zone (cfg_zone),
        .wr_val  (cfg_ws),
        .ws_q    (ws_q)
    );

    always_comb begin
        sel_ws = '0;
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (dec_zone == ZIDX_W'(z)) sel_ws = ws_q[z];
        end
    end

    assign go = core_req && dec_ext && seq_idle;

    wsz_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_we     (core_we),
        .go_addr   (core_addr),
        .go_wdata  (core_wdata),
        .go_ws     (sel_ws),
        .ext_din   (ext_din),
        .idle      (seq_idle),
        .last      (seq_last),
        .rdata     (core_rdata),
        .ext_addr  (ext_addr),
        .ext_dout  (ext_dout),
        .ext_oe    (ext_oe),
        .ext_sel_n (ext_sel_n),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n)
    );

    assign core_int_hit  = core_req && dec_int;
    assign core_ctrl_hit = core_req && dec_ctrl;
    assign core_ready    = seq_last || (core_req && seq_idle && !dec_ext);

    p_region_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({dec_ext, dec_int, dec_ctrl}));
    p_int_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_int_hit && ext_sel_n) |-> core_ready);
    p_ctrl_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ctrl_hit && ext_sel_n) |-> core_ready);
endmodule

// File: tb/tb_wsz_ctrl.sv
module tb_wsz_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, core_we = 1'b0;
    logic [13:0] core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic        core_ready, core_int_hit, core_ctrl_hit;
    logic [15:0] core_rdata;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_zone = '0, cfg_ws = '0;
    logic [13:0] ext_addr;
    logic [23:0] ext_dout;
    logic        ext_oe, ext_sel_n, ext_rd_n, ext_wr_n;
    logic [23:0] ext_din = '0;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wsz_ctrl dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_ws(input int z, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_zone = 3'(z); cfg_ws = 3'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Region: 0..4 zone, 5 on-chip RAM, 6 control (INT_WORDS = 512)
    function automatic int region(input int a);
        if (a < 'h400)  return 0;
        if (a < 'h800)  return 1;
        if (a < 'h3000) return 2;
        if (a < 'h3400) return 3;
        if (a < 'h3800) return 4;
        if (a < 'h3A00) return 5;
        return 6;
    endfunction

    task automatic access(input int a, input bit w, input int wd,
                          input bit inj, input int injz, input int injv,
                          output int ncyc, output int rd, output bit ih,
                          output bit ch, output bit bad, output bit extra_rdy);
        logic [15:0] w16;
        w16 = 16'(wd);
        bad = 0; ncyc = 0; rd = 0; extra_rdy = 0;
        @(negedge clk);
        core_req = 1'b1; core_addr = 14'(a); core_we = w; core_wdata = w16;
        ext_din = {16'(a * 7 + 16'h1357), 8'hA5};
        #2;
        ih = core_int_hit; ch = core_ctrl_hit;
        if (core_ready) begin
            rd = int'(core_rdata);
            if (!ext_sel_n || !ext_rd_n || !ext_wr_n) bad = 1;
            @(negedge clk);
            core_req = 1'b0;
            return;
        end
        @(negedge clk);
        core_req = 1'b0;
        if (inj) begin
            cfg_we = 1'b1; cfg_zone = 3'(injz); cfg_ws = 3'(injv);
        end
        for (int k = 0; k < 20; k++) begin
            if (ext_sel_n || ext_addr != 14'(a)) bad = 1;
            if (w && (ext_wr_n || !ext_rd_n || !ext_oe || ext_dout != {w16, 8'h00})) bad = 1;
            if (!w && (ext_rd_n || !ext_wr_n || ext_oe)) bad = 1;
            ncyc++;
            if (core_ready) begin
                rd = int'(core_rdata);
                break;
            end
            @(negedge clk);
            cfg_we = 1'b0;
        end
        cfg_we = 1'b0;
        @(negedge clk);
        if (!ext_sel_n || core_ready) extra_rdy = 1;
    endtask

    initial begin
        int n, rd, expd;
        bit ih, ch, bad, xr;
        // R4: reset state
        #5;
        chk(ext_sel_n && ext_rd_n && ext_wr_n && !ext_oe && !core_ready, "R4",
            "idle strobes in reset", int'({ext_sel_n, ext_rd_n, ext_wr_n, ext_oe, core_ready}), 5'b11100);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ext_sel_n && ext_rd_n && ext_wr_n && !ext_oe && !core_ready, "R4",
            "idle strobes after reset", int'({ext_sel_n, ext_rd_n, ext_wr_n, ext_oe, core_ready}), 5'b11100);

        // R4/R6: every zone defaults to 7 wait states -> 8 strobe cycles
        for (int z = 0; z < 5; z++) begin
            access(int'(wsz_pkg::zone_base(z)), 1'b0, 0, 0, 0, 0, n, rd, ih, ch, bad, xr);
            chk(n == 8, "R4", "default access length", n, 8);
        end

        // R5 R6 R9 R10 R11: each zone, each count, read and write
        for (int z = 0; z < 5; z++) begin
            for (int v = 0; v < 8; v++) begin
                int a;
                a = int'(wsz_pkg::zone_base(z)) + 37 * (v + 1);
                set_ws(z, v);
                access(a, 1'b0, 0, 0, 0, 0, n, rd, ih, ch, bad, xr);
                expd = (a * 7 + 'h1357) & 'hFFFF;
                chk(n == v + 1, "R6", "read length", n, v + 1);
                chk(!bad, "R5", "read strobes/address (R11)", int'(bad), 0);
                chk(!xr, "R6", "ready/select after last cycle", int'(xr), 0);
                chk(rd == expd, "R10", "read data", rd, expd);
                access(a, 1'b1, (a ^ 'hBEEF) & 'hFFFF, 0, 0, 0, n, rd, ih, ch, bad, xr);
                chk(n == v + 1, "R6", "write length", n, v + 1);
                chk(!bad, "R9", "write lanes/strobes/oe", int'(bad), 0);
            end
        end

        // R1 R2 R3: address sweep with distinct counts per zone
        for (int z = 0; z < 5; z++) set_ws(z, z + 1);
        for (int i = 0; i < 141; i++) begin
            int a, r;
            int bnd[13] = '{'h03FF, 'h0400, 'h07FF, 'h0800, 'h2FFF, 'h3000,
                            'h33FF, 'h3400, 'h37FF, 'h3800, 'h39FF, 'h3A00, 'h3FFF};
            a = (i < 128) ? i * 'h80 : bnd[i - 128];
            r = region(a);
            access(a, i[0], i, 0, 0, 0, n, rd, ih, ch, bad, xr);
            if (r < 5) begin
                chk(n == r + 2 && !ih && !ch, "R1", "zone access length", n, r + 2);
            end else if (r == 5) begin
                chk(n == 0 && ih && !ch && !bad, "R2", "on-chip RAM hit", n * 4 + int'({ih, ch}), 2);
            end else begin
                chk(n == 0 && !ih && ch && !bad, "R3", "control region hit", n * 4 + int'({ih, ch}), 1);
            end
        end

        // R7: writes to zone indices 5..7 change nothing
        set_ws(5, 0); set_ws(6, 0); set_ws(7, 0);
        for (int z = 0; z < 5; z++) begin
            access(int'(wsz_pkg::zone_base(z)) + 5, 1'b0, 0, 0, 0, 0, n, rd, ih, ch, bad, xr);
            chk(n == z + 2, "R7", "count after out-of-range write", n, z + 2);
        end

        // R8: mid-access reprogramming affects only the next access
        set_ws(0, 3);
        access('h10, 1'b0, 0, 1, 0, 0, n, rd, ih, ch, bad, xr);
        chk(n == 4, "R8", "length during reprogram", n, 4);
        access('h10, 1'b0, 0, 0, 0, 0, n, rd, ih, ch, bad, xr);
        chk(n == 1, "R8", "length after reprogram", n, 1);

        finished = 1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule